// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Edge-Event Interrupts

This block gives a chip a bank of general-purpose I/O lines (32 by default) that software drives and reads through a small word-wide register bus. Each line can be an input or an output, selected per line. Output lines present a value and an enable on separate vectors, so the pad ring owns the tristate buffers. Input lines pass through a synchroniser. A per-line input gate then decides whether the pad value is visible in the data register.

Every line feeds an edge detector that records transitions in an event register. Per line, the detector counts either falling edges only or both edges. Software acknowledges an event by writing a one to its bit. A mask register selects which recorded events raise the single interrupt output. Register bits are numbered in reverse: line 0 sits in the most significant bit of every register.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers decode at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge select and 0x18 input enable. Direction, open-drain, mask, edge select and input enable read back the last value written.
- R2: Line n corresponds to register bit NLINES-1-n in every register. `pad_oe[n]` equals direction bit NLINES-1-n (1 = output). `pad_out[n]` equals data bit NLINES-1-n.
- R3: A read of offset 0x08 returns the written data bit for output lines. For input lines it returns the synchronised pad value, which shows up two rising edges after the pad changes.
- R4: An input line whose input-enable bit is 0 reads as 0 in the data register, whatever its pad level.
- R5: A pad transition sets its event bit at the third rising clock edge after the change: two synchroniser stages, then one edge-compare stage.
- R6: Edge-select bit 1 means only a 1-to-0 transition sets the event bit. Edge-select bit 0 means either transition sets it. Detection works on the synchronised pad regardless of direction.
- R7: Writing offset 0x0C clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R8: `irq` is high exactly when some bit is set in both the event and mask registers.
- R9: If an edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R10: After reset, all registers read 0. The one exception is the input-enable register, which reads all ones when parameter IBE_RST_ONES is 1.
- R11: Reads of any other offset return 0, and writes to them change no register.
- R12: Writing all ones to the event register and then zero to the mask register leaves every event clear and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data for `bus_addr`, combinational |
| pad_in | input | NLINES | Pad levels, bit n is line n, asynchronous |
| pad_out | output | NLINES | Output value, bit n is line n |
| pad_oe | output | NLINES | Output enable, bit n is line n |
| irq | output | 1 | Combined masked event interrupt |

## Verification
The assertions take for granted that a bus write lasts a single cycle with its address and data stable across the edge. They also assume reset is held for at least one clock edge, so every `$past` value comes from reset or from a normal cycle. Pad inputs may change at any time; the checker looks only at the synchronised copies. The stimulus drives the bus and pads on the falling clock edge and holds reset for several cycles. It lets each pad change settle for three rising edges before the next change, except where it deliberately makes an edge and a clear meet.

// File: rtl/gpio_edge_pkg.sv
// Shared constants for the GPIO controller: bus address width and register offsets.
// Assumes byte addressing with word-aligned registers.
package gpio_edge_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OPEN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EVENT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_INEN  = 8'h18;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchroniser for asynchronous pad levels, plus one extra
// register that holds the synchronised value from the previous cycle.
// Assumes STAGES >= 2; every bit is treated independently.
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_now,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] chain [STAGES];

    // Shift pad levels through the synchroniser chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            sync_prev <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sync_prev <= chain[STAGES-1];
        end
    end

    assign sync_now = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_unit.sv
// Per-line edge classifier and sticky event register with write-one-to-clear.
// Assumes sync_now/sync_prev are consecutive samples of the same synchronised line.
// A new edge overrides a simultaneous clear of the same bit.
module gpio_evt_unit #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_now,
    input  logic [W-1:0] sync_prev,
    input  logic [W-1:0] fall_only,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] edge_hit,
    output logic [W-1:0] evt_q
);
    // Classify each line's transition according to its edge-select bit.
    for (genvar i = 0; i < W; i++) begin : g_edge
        logic rise_w;
        logic fall_w;
        assign rise_w      = sync_now[i] & ~sync_prev[i];
        assign fall_w      = ~sync_now[i] & sync_prev[i];
        assign edge_hit[i] = fall_only[i] ? fall_w : (rise_w | fall_w);
    end

    logic [W-1:0] clr_w;
    assign clr_w = clr_en ? clr_bits : '0;

    // Latch events; a fresh edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_w) | edge_hit;
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
// GPIO controller top: register file, bit-reversed line mapping, input gating,
// edge events and the combined interrupt. Assumes bus_we is a one-cycle strobe
// and that pad_in is asynchronous to clk. Register bit NLINES-1-n is line n.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NLINES       = 32,
    parameter bit          IBE_RST_ONES = 1'b0,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq
);
    localparam logic [NLINES-1:0] INEN_RST = IBE_RST_ONES ? '1 : '0;

    logic [NLINES-1:0] dir_q, open_q, dat_q, mask_q, ecfg_q, inen_q;
    logic [NLINES-1:0] pin_reg, sync_now, sync_prev, edge_hit, evt_q;
    logic [NLINES-1:0] data_view;
    logic              evt_clr;

    // Map line-indexed pads onto register bit order and back.
    for (genvar n = 0; n < NLINES; n++) begin : g_map
        assign pin_reg[NLINES-1-n] = pad_in[n];
        assign pad_oe[n]           = dir_q[NLINES-1-n];
        assign pad_out[n]          = dat_q[NLINES-1-n];
    end

    gpio_in_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_reg),
        .sync_now  (sync_now),
        .sync_prev (sync_prev)
    );

    assign evt_clr = bus_we && (bus_addr == OFS_EVENT);

    gpio_evt_unit #(.W(NLINES)) evt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_now  (sync_now),
        .sync_prev (sync_prev),
        .fall_only (ecfg_q),
        .clr_en    (evt_clr),
        .clr_bits  (bus_wdata),
        .edge_hit  (edge_hit),
        .evt_q     (evt_q)
    );

    // Update configuration registers on a bus write to their offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            open_q <= '0;
            dat_q  <= '0;
            mask_q <= '0;
            ecfg_q <= '0;
            inen_q <= INEN_RST;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_DIR:  dir_q  <= bus_wdata;
                OFS_OPEN: open_q <= bus_wdata;
                OFS_DATA: dat_q  <= bus_wdata;
                OFS_MASK: mask_q <= bus_wdata;
                OFS_EDGE: ecfg_q <= bus_wdata;
                OFS_INEN: inen_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Outputs show stored data; enabled inputs show the synchronised pad.
    assign data_view = (dat_q & dir_q) | (sync_now & ~dir_q & inen_q);

    // Select read data by offset; unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            OFS_DIR:   bus_rdata = dir_q;
            OFS_OPEN:  bus_rdata = open_q;
            OFS_DATA:  bus_rdata = data_view;
            OFS_EVENT: bus_rdata = evt_q;
            OFS_MASK:  bus_rdata = mask_q;
            OFS_EDGE:  bus_rdata = ecfg_q;
            OFS_INEN:  bus_rdata = inen_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Property checker for gpio_edge_ctrl, attached by bind. Assumes one-cycle
// bus writes and a reset held for at least one clock edge.
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NLINES-1:0] bus_wdata,
    input logic              irq,
    input logic [NLINES-1:0] evt_q,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] ecfg_q,
    input logic [NLINES-1:0] edge_hit,
    input logic [NLINES-1:0] sync_now
);
    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_EVENT) |=> ((evt_q & $past(bus_wdata) & ~$past(edge_hit)) == '0));

    // R6
    evt_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0));

    // R6
    fall_only_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & ecfg_q & sync_now) == '0));

    // R8
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~evt_q & $past(edge_hit)) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NLINES(NLINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .ecfg_q    (ecfg_q),
    .edge_hit  (edge_hit),
    .sync_now  (sync_now)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_ones;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_out2, pad_oe2;
    logic        irq, irq2;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl #(.NLINES(32), .IBE_RST_ONES(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    gpio_edge_ctrl #(.NLINES(32), .IBE_RST_ONES(1'b1)) dut_ones_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_ones), .pad_in(pad_in),
        .pad_out(pad_out2), .pad_oe(pad_oe2), .irq(irq2));

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hF0F0_0000}, '{1'b0, 8'h00, 32'hF0F0_0000},
        '{1'b1, 8'h04, 32'h0000_00A5}, '{1'b0, 8'h04, 32'h0000_00A5},
        '{1'b1, 8'h14, 32'h1234_5678}, '{1'b0, 8'h14, 32'h1234_5678},
        '{1'b1, 8'h10, 32'h8000_0001}, '{1'b0, 8'h10, 32'h8000_0001},
        '{1'b1, 8'h18, 32'hFFFF_FFFF}, '{1'b0, 8'h18, 32'hFFFF_FFFF},
        '{1'b1, 8'h1C, 32'hDEAD_BEEF}, '{1'b0, 8'h1C, 32'h0000_0000},
        '{1'b0, 8'h20, 32'h0000_0000}, '{1'b0, 8'h00, 32'hF0F0_0000},
        '{1'b0, 8'h04, 32'h0000_00A5}, '{1'b1, 8'h00, 32'h0000_0000},
        '{1'b1, 8'h14, 32'h0000_0000}, '{1'b1, 8'h10, 32'h0000_0000},
        '{1'b0, 8'h08, 32'h0000_0000}
    };

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(5);
        // R10: reset values, both input-enable reset choices
        rd_chk("R10 dir", 8'h00, 32'h0);
        rd_chk("R10 open", 8'h04, 32'h0);
        rd_chk("R10 data", 8'h08, 32'h0);
        rd_chk("R10 event", 8'h0C, 32'h0);
        rd_chk("R10 mask", 8'h10, 32'h0);
        rd_chk("R10 edge", 8'h14, 32'h0);
        rd_chk("R10 inen", 8'h18, 32'h0);
        bus_addr = 8'h18; #1;
        check("R10 inen ones", rdata_ones, 32'hFFFF_FFFF);
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 oe", pad_oe, 32'h0);
        rst_n = 1'b1;
        step();

        // R1 and R11: register table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd_chk((VECS[i].addr > 8'h18) ? "R11 unmapped" : "R1 readback",
                        VECS[i].addr, VECS[i].data);
        end

        // R2: bit-reversed output mapping (lines 0 and 1 outputs, line 1 high)
        wr(8'h08, 32'h4000_0000);
        wr(8'h00, 32'hC000_0000);
        check("R2 pad_oe", pad_oe, 32'h0000_0003);
        check("R2 pad_out", pad_out & pad_oe, 32'h0000_0002);
        // R3: data view mixes outputs and synchronised inputs
        pad_in = 32'hFFFF_FFFF;
        step(3);
        rd_chk("R3 mixed", 8'h08, 32'h7FFF_FFFF);
        // R4: gated input buffer
        wr(8'h18, 32'h0);
        rd_chk("R4 gated", 8'h08, 32'h4000_0000);
        // R6: output lines also record edges
        rd_chk("R6 all lines", 8'h0C, 32'hFFFF_FFFF);
        check("R8 masked off", {31'b0, irq}, 32'h0);

        // R12: acknowledge-all and mask-none sequence
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        rd_chk("R12 events", 8'h0C, 32'h0);
        check("R12 irq", {31'b0, irq}, 32'h0);

        wr(8'h00, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0;
        step(3);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R7 clear all", 8'h0C, 32'h0);

        // R5: latency of line 5 (bit 26) rising edge, both-edge mode
        wr(8'h10, 32'hFFFF_FFFF);
        pad_in[5] = 1'b1;
        step();
        rd_chk("R3 not yet", 8'h08, 32'h0);
        rd_chk("R5 early1", 8'h0C, 32'h0);
        step();
        rd_chk("R3 synced", 8'h08, 32'h0400_0000);
        rd_chk("R5 early2", 8'h0C, 32'h0);
        step();
        rd_chk("R5 set", 8'h0C, 32'h0400_0000);
        check("R8 irq set", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0400_0000);
        rd_chk("R7 ack", 8'h0C, 32'h0);
        check("R8 irq clear", {31'b0, irq}, 32'h0);
        pad_in[5] = 1'b0;
        step(3);
        rd_chk("R6 both fall", 8'h0C, 32'h0400_0000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R6: falling-only mode on line 7 (bit 24)
        wr(8'h14, 32'h0100_0000);
        pad_in[7] = 1'b1;
        step(3);
        rd_chk("R6 rise ignored", 8'h0C, 32'h0);
        pad_in[7] = 1'b0;
        step(3);
        rd_chk("R6 fall seen", 8'h0C, 32'h0100_0000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R7: selective clear of lines 2 and 3 (bits 29, 28)
        pad_in[2] = 1'b1; pad_in[3] = 1'b1;
        step(3);
        rd_chk("R7 both set", 8'h0C, 32'h3000_0000);
        wr(8'h0C, 32'h1000_0000);
        rd_chk("R7 one cleared", 8'h0C, 32'h2000_0000);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        wr(8'h10, 32'hDFFF_FFFF);
        check("R8 masked", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        check("R8 unmasked", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R9: edge on line 4 (bit 27) coincides with its clear
        pad_in[4] = 1'b1;
        step(3);
        rd_chk("R9 pre", 8'h0C, 32'h0800_0000);
        pad_in[4] = 1'b0;
        step(2);
        wr(8'h0C, 32'h0800_0000);
        rd_chk("R9 edge wins", 8'h0C, 32'h0800_0000);
        wr(8'h0C, 32'h0800_0000);
        rd_chk("R7 later clear", 8'h0C, 32'h0);

        finish_run();
    end
endmodule